// File: doc/BRIEF.md
# Serial Configuration Loader

This block keeps a device's static configuration up to date by reading it, over and over, from an external parallel-in/serial-out shift register. Once per frame the block raises a select output that makes the external register take in its parallel inputs. It then lowers the select so that the register shifts its contents out one bit per clock into the block's single serial input. The block and the external register run from the same clock, and both act on its rising edge.

The received bits collect in an internal capture register. At the end of each frame the block copies them, in one clock, into stable output registers: a 5-bit bus address and six single-bit settings. The settings are talk-only, listen-only, the single-role addressing mode, request-for-service, return-to-local and individual-status. A partly shifted word never reaches the outputs. Because the frame repeats without pause, a change on the external register's parallel inputs reaches the outputs within 16 to 32 clocks.

The addressing mode bit is only passed on. When it is high, the logic that uses it lets the device be a listener or a talker, but not both at once. When it is low, the device may be both at the same time. The address comparison itself is not part of this block.

Top module: `sercfg_loader`

## Requirements
- R1: `load_o` is high for exactly one clock in every frame of `FRAME_LEN` (default 16) clocks and low for the rest of the frame.
- R2: During the 11 clocks that follow the load clock, the block captures `ser_i` on each rising edge. The external register sends its parallel word most significant bit first. In that word, bits 10 down to 6 are the address (bit 10 is the address MSB), bit 5 is talk-only, bit 4 listen-only, bit 3 the mode, bit 2 request-for-service, bit 1 return-to-local and bit 0 individual-status.
- R3: `addr_o[4:0]` equals bits 10 to 6 of the word loaded in the frame that was last completed.
- R4: `talk_only_o`, `listen_only_o`, `single_role_o`, `svc_req_o`, `ret_local_o` and `ind_status_o` equal bits 5, 4, 3, 2, 1 and 0 of that word.
- R5: All output registers change together, only on the last clock edge of a frame. They therefore only change in a cycle in which `load_o` is high.
- R6: Serial bits that arrive after the eleventh shift of a frame have no effect on any output.
- R7: A change on the external register's parallel inputs appears at the outputs no sooner than 16 and no later than 32 rising edges after the change.
- R8: While `pon_i` is high, every configuration output is 0 and `load_o` is 1. This holds asynchronously, and the frame restarts from its load clock.
- R9: After `pon_i` falls, the outputs stay 0 for 15 rising edges and show the loaded word after the 16th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the external shift register |
| pon_i | input | 1 | Power-on reset, active high, asynchronous |
| ser_i | input | 1 | Serial data from the external register |
| load_o | output | 1 | 1 = external register loads in parallel, 0 = shifts |
| addr_o | output | 5 | Bus address |
| talk_only_o | output | 1 | Talk-only setting |
| listen_only_o | output | 1 | Listen-only setting |
| single_role_o | output | 1 | Addressing mode: 1 = listener or talker, 0 = both allowed |
| svc_req_o | output | 1 | Request-for-service setting |
| ret_local_o | output | 1 | Return-to-local setting |
| ind_status_o | output | 1 | Individual-status setting |

## Verification
The bench builds the block with the default `FRAME_LEN` of 16, so the 11 kept bits are followed by four trailing shifts. The bench's external register model fills with ones, so those trailing shifts carry ones, and an all-zero word proves that the extra bits are discarded. Parallel input changes are applied at many different offsets within the frame, which brings both latency bounds within reach. Single-bit words check each field position on its own. A reset applied in the middle of a frame tests the restart and the timing of the first frame.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int ADDR_W = 5;
    localparam int FLAG_W = 6;
    localparam int CFG_W  = ADDR_W + FLAG_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              talk_only;
        logic              listen_only;
        logic              single_role;
        logic              svc_req;
        logic              ret_local;
        logic              ind_status;
    } cfg_t;

endpackage

// File: rtl/sercfg_frame_seq.sv
module sercfg_frame_seq #(
    parameter int FRAME_LEN = 16,
    parameter int KEEP_BITS = 11
) (
    input  logic clk_i,
    input  logic pon_i,
    output logic load_o,
    output logic cap_en_o,
    output logic commit_o
);
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] KEEP = CNT_W'(KEEP_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.cnt == LAST) begin
            seq_d.cnt = '0;
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge pon_i) begin
        if (pon_i) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // slot 0 loads, slots 1..KEEP capture, last slot commits
    assign load_o   = (seq_q.cnt == '0);
    assign cap_en_o = (seq_q.cnt != '0) && (seq_q.cnt <= KEEP);
    assign commit_o = (seq_q.cnt == LAST);

endmodule

// File: rtl/sercfg_capture.sv
module sercfg_capture #(
    parameter int WIDTH = 11
) (
    input  logic             clk_i,
    input  logic             pon_i,
    input  logic             cap_en_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] word_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cap_en_i) begin
            // first bit received ends up in the MSB
            cap_d.sr = {cap_q.sr[WIDTH-2:0], ser_i};
        end
    end

    always_ff @(posedge clk_i or posedge pon_i) begin
        if (pon_i) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word_o = cap_q.sr;

endmodule

// File: rtl/sercfg_hold.sv
module sercfg_hold
    import sercfg_pkg::*;
(
    input  logic             clk_i,
    input  logic             pon_i,
    input  logic             commit_i,
    input  logic [CFG_W-1:0] word_i,
    output cfg_t             cfg_o
);
    typedef struct packed {
        cfg_t cfg;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (commit_i) begin
            hold_d.cfg = cfg_t'(word_i);
        end
    end

    always_ff @(posedge clk_i or posedge pon_i) begin
        if (pon_i) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign cfg_o = hold_q.cfg;

endmodule

// File: rtl/sercfg_loader.sv
module sercfg_loader
    import sercfg_pkg::*;
#(
    parameter int FRAME_LEN = 16
) (
    input  logic              clk_i,
    input  logic              pon_i,
    input  logic              ser_i,
    output logic              load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              talk_only_o,
    output logic              listen_only_o,
    output logic              single_role_o,
    output logic              svc_req_o,
    output logic              ret_local_o,
    output logic              ind_status_o
);
    logic             cap_en;
    logic             commit;
    logic [CFG_W-1:0] word;
    cfg_t             cfg;

    sercfg_frame_seq #(
        .FRAME_LEN (FRAME_LEN),
        .KEEP_BITS (CFG_W)
    ) u_seq (
        .clk_i    (clk_i),
        .pon_i    (pon_i),
        .load_o   (load_o),
        .cap_en_o (cap_en),
        .commit_o (commit)
    );

    sercfg_capture #(
        .WIDTH (CFG_W)
    ) u_cap (
        .clk_i    (clk_i),
        .pon_i    (pon_i),
        .cap_en_i (cap_en),
        .ser_i    (ser_i),
        .word_o   (word)
    );

    sercfg_hold u_hold (
        .clk_i    (clk_i),
        .pon_i    (pon_i),
        .commit_i (commit),
        .word_i   (word),
        .cfg_o    (cfg)
    );

    assign addr_o        = cfg.addr;
    assign talk_only_o   = cfg.talk_only;
    assign listen_only_o = cfg.listen_only;
    assign single_role_o = cfg.single_role;
    assign svc_req_o     = cfg.svc_req;
    assign ret_local_o   = cfg.ret_local;
    assign ind_status_o  = cfg.ind_status;

endmodule

// File: rtl/sercfg_loader_chk.sv
module sercfg_loader_chk
    import sercfg_pkg::*;
#(
    parameter int FRAME_LEN = 16
) (
    input logic              clk_i,
    input logic              pon_i,
    input logic              load_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              talk_only_o,
    input logic              listen_only_o,
    input logic              single_role_o,
    input logic              svc_req_o,
    input logic              ret_local_o,
    input logic              ind_status_o
);
    localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    logic [CW-1:0]    slot_q;
    logic [CFG_W-1:0] outs;

    assign outs = {addr_o, talk_only_o, listen_only_o, single_role_o,
                   svc_req_o, ret_local_o, ind_status_o};

    always_ff @(posedge clk_i or posedge pon_i) begin
        if (pon_i) begin
            slot_q <= '0;
        end else if (slot_q == CW'(FRAME_LEN - 1)) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    AST_LOAD_PERIOD: assert property (@(posedge clk_i) disable iff (pon_i)
        load_o == (slot_q == '0)); // R1

    AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (pon_i)
        load_o |=> !load_o); // R1

    AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (pon_i)
        !load_o |-> $stable(outs)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (pon_i)
        $past(pon_i) |-> (outs == '0 && load_o)); // R8

endmodule

bind sercfg_loader sercfg_loader_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk_i         (clk_i),
    .pon_i         (pon_i),
    .load_o        (load_o),
    .addr_o        (addr_o),
    .talk_only_o   (talk_only_o),
    .listen_only_o (listen_only_o),
    .single_role_o (single_role_o),
    .svc_req_o     (svc_req_o),
    .ret_local_o   (ret_local_o),
    .ind_status_o  (ind_status_o)
);

// File: tb/tb_sercfg_loader.sv
`timescale 1ns/1ps
module tb_sercfg_loader;

    logic        clk_i = 1'b0;
    logic        pon_i = 1'b1;
    logic        ser_i;
    logic        load_o;
    logic [4:0]  addr_o;
    logic        talk_only_o, listen_only_o, single_role_o;
    logic        svc_req_o, ret_local_o, ind_status_o;

    logic [10:0] par  = 11'h000;
    logic [10:0] ext  = 11'h000;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #5 clk_i = ~clk_i;

    // external parallel-in/serial-out register, fills with ones
    always @(posedge clk_i) begin
        if (load_o) ext <= par;
        else        ext <= {ext[9:0], 1'b1};
    end
    assign ser_i = ext[10];

    sercfg_loader dut (
        .clk_i(clk_i), .pon_i(pon_i), .ser_i(ser_i), .load_o(load_o),
        .addr_o(addr_o), .talk_only_o(talk_only_o),
        .listen_only_o(listen_only_o), .single_role_o(single_role_o),
        .svc_req_o(svc_req_o), .ret_local_o(ret_local_o),
        .ind_status_o(ind_status_o)
    );

    function automatic logic [5:0] flags();
        return {talk_only_o, listen_only_o, single_role_o,
                svc_req_o, ret_local_o, ind_status_o};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // {parallel word, expected address, expected flags}
    localparam logic [21:0] VEC [13] = '{
        {11'h7FF, 5'h1F, 6'h3F},
        {11'h400, 5'h10, 6'h00},
        {11'h040, 5'h01, 6'h00},
        {11'h020, 5'h00, 6'h20},
        {11'h010, 5'h00, 6'h10},
        {11'h008, 5'h00, 6'h08},
        {11'h004, 5'h00, 6'h04},
        {11'h002, 5'h00, 6'h02},
        {11'h001, 5'h00, 6'h01},
        {11'h555, 5'h15, 6'h15},
        {11'h2AA, 5'h0A, 6'h2A},
        {11'h000, 5'h00, 6'h00},
        {11'h3C5, 5'h0F, 6'h05}
    };

    // R1 and R5 monitors
    logic [10:0] prev_outs = '0;
    int          gap = 0;
    bit          gap_ok = 0;
    always @(negedge clk_i) begin
        if (pon_i) begin
            gap_ok = 0;
            gap = 0;
            prev_outs = '0;
        end else if (!done) begin
            gap++;
            if (load_o) begin
                if (gap_ok) check(gap == 16, "R1 load period", gap, 16);
                gap_ok = 1;
                gap = 0;
            end
            if ({addr_o, flags()} != prev_outs)
                check(load_o == 1'b1, "R5 outputs change only at frame end", load_o, 1);
            prev_outs = {addr_o, flags()};
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R8 reset state
        check({addr_o, flags()} == 0, "R8 outputs zero in reset", {addr_o, flags()}, 0);
        check(load_o == 1'b1, "R8 load high in reset", load_o, 1);
        pon_i = 1'b0;

        foreach (VEC[i]) begin
            int first;
            first = 0;
            repeat ((i * 5) % 16) @(negedge clk_i);
            par = VEC[i][21:11];
            for (int k = 1; k <= 32; k++) begin
                @(negedge clk_i);
                if (first == 0 && addr_o == VEC[i][10:6] && flags() == VEC[i][5:0])
                    first = k;
            end
            check(addr_o == VEC[i][10:6], "R3 address field", addr_o, VEC[i][10:6]);
            check(flags() == VEC[i][5:0], "R4 setting bits (R2 order, R6 trailing)",
                  flags(), VEC[i][5:0]);
            check(first >= 16 && first <= 32, "R7 latency", first, 32);
        end

        // R6: all-zero word, trailing shifts carry ones
        par = 11'h000;
        repeat (40) @(negedge clk_i);
        check({addr_o, flags()} == 0, "R6 trailing bits ignored", {addr_o, flags()}, 0);

        // R8 mid-frame reset, R9 first frame
        par = 11'h6B3;
        repeat (37) @(negedge clk_i);
        pon_i = 1'b1;
        @(negedge clk_i);
        check({addr_o, flags()} == 0, "R8 mid-frame reset clears", {addr_o, flags()}, 0);
        check(load_o == 1'b1, "R8 frame restarts at load", load_o, 1);
        @(negedge clk_i);
        pon_i = 1'b0;
        repeat (15) @(negedge clk_i);
        check({addr_o, flags()} == 0, "R9 still zero after 15 edges", {addr_o, flags()}, 0);
        @(negedge clk_i);
        check({addr_o, flags()} == 11'h6B3, "R9 word after 16 edges",
              {addr_o, flags()}, 11'h6B3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule